// File: doc/BRIEF.md
# Comparator Output Digital Filter

This block takes the one-bit result of an analog comparator, which reaches the digital side as a possibly asynchronous level, and turns it into a clean logic signal. The raw level first passes through a flop synchronizer. A programmable polarity flip is then applied, giving the unfiltered result. The filter samples that result and moves its output to a new level only after a programmed number of consecutive samples agree.

Sampling instants come from one of two sources. The first is an internal counter that fires once every programmed number of bus clock cycles. The second is the rising edge of an external sample strobe. All settings arrive as plain inputs from the surrounding control logic. A sample count of zero has a different meaning in each source mode, and a period of zero bypasses the filter in counter mode.

Top module: `cmp_out_filter`

## Requirements
- R1: With a sample count N from 2 to 7, the filtered output takes a new level only on the sampling instant that completes N consecutive equal samples of that level. With a period of 1, a change at the raw input appears at the filtered output N+2 clock edges after it is applied.
- R2: With a sample count of 1, every sampling instant copies the unfiltered result to the filtered output, 3 edges after a raw change when the period is 1.
- R3: A sample count of 0 with counter mode selected (ext_sample_i = 0) makes the filtered output equal the unfiltered output.
- R4: A sample count of 0 with strobe mode selected (ext_sample_i = 1) forces the filtered output to 0.
- R5: In counter mode a period P from 1 to 255 produces one sampling instant every P clock cycles, so a raw change with count N appears after 3+(N-1)·P to 2+N·P edges. A period of 0 makes the output follow the unfiltered result.
- R6: In strobe mode the period is ignored. Each low-to-high transition of strobe_i, seen at a clock edge, is one sampling instant, and a strobe held high counts only once.
- R7: The unfiltered output equals the synchronized raw input XOR inv_i. A raw change reaches it 2 clock edges after it is applied.
- R8: While en_i is low, both outputs read inv_i, and the stored filter level is reset to inv_i with the agreement run cleared.
- R9: A sample that differs from the previous sample restarts the agreement run at one, so a raw pulse shorter than N sampling instants never reaches the filtered output.
- R10: Any change of sample count, period or source mode restarts the agreement run and the period counter, while the filtered output keeps its present level.
- R11: After reset, with en_i and inv_i low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Module enable |
| inv_i | input | 1 | Invert the comparator result |
| ext_sample_i | input | 1 | 1: external strobe sets sampling instants; 0: internal period counter |
| cnt_i | input | CNT_W (3) | Consecutive equal samples required |
| period_i | input | PER_W (8) | Sampling interval in clock cycles (counter mode) |
| cmp_raw_i | input | 1 | Raw comparator level, asynchronous |
| strobe_i | input | 1 | External sample strobe |
| filt_o | output | 1 | Filtered output |
| unfilt_o | output | 1 | Synchronized, polarity-adjusted unfiltered output |

## Verification
A raw change reaches the unfiltered output two edges later, and the filtered output 2+N edges later when the period is 1. The bench therefore counts clock edges from the negative edge at which it drives the raw input until the output moves, and compares that count exactly. For longer periods the phase of the free-running counter is not known, so the count is checked against the window from 3+(N-1)·P to 2+N·P edges. In strobe mode every pulse takes three negative edges and produces one sampling instant. The bench samples the output after N-1 pulses and again after N pulses, so the result is exact without any timing window.

// File: rtl/cof_pkg.sv
package cof_pkg;
   typedef enum logic {
      TICK_PERIOD = 1'b0,
      TICK_STROBE = 1'b1
   } tick_src_e;
endpackage

// File: rtl/cof_sync.sv
module cof_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cof_tick_gen.sv
module cof_tick_gen
   import cof_pkg::*;
#(
   parameter int PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tick_src_e        src_i,
   input  logic [PER_W-1:0] period_i,
   input  logic             strobe_i,
   input  logic             restart_i,
   output logic             tick_o
);
   localparam logic [PER_W-1:0] ONE = PER_W'(1);

   logic [PER_W-1:0] per_q;
   logic             strobe_q;
   logic             per_end;
   logic             period_tick;
   logic             strobe_tick;

   assign per_end     = (period_i != '0) && (per_q >= period_i - ONE);
   assign period_tick = (src_i == TICK_PERIOD) && per_end && !restart_i;
   assign strobe_tick = (src_i == TICK_STROBE) && strobe_i && !strobe_q && !restart_i;
   assign tick_o      = period_tick || strobe_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= strobe_i;
         if (restart_i || (src_i == TICK_STROBE) || (period_i == '0) || per_end)
            per_q <= '0;
         else
            per_q <= per_q + ONE;
      end
   end

   // R5: with a period above one, two ticks never come back to back
   a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && src_i == TICK_PERIOD && period_i > ONE) |=> !tick_o);

   // R6: a strobe held high yields a single tick
   a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && src_i == TICK_STROBE) |=> !tick_o);
endmodule

// File: rtl/cof_agree.sv
module cof_agree #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             clear_val_i,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic             sample_i,
   input  logic [CNT_W-1:0] need_i,
   output logic             held_o
);
   localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_nxt;
   logic             last_q;
   logic             held_q;
   logic             accept;

   always_comb begin
      if ((run_q != '0) && (sample_i == last_q))
         run_nxt = (run_q == RUN_MAX) ? RUN_MAX : run_q + RUN_ONE;
      else
         run_nxt = RUN_ONE;
   end

   assign accept = (need_i != '0) && (run_nxt >= need_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         last_q <= 1'b0;
         held_q <= 1'b0;
      end else if (clear_i) begin
         run_q  <= '0;
         last_q <= 1'b0;
         held_q <= clear_val_i;
      end else if (restart_i) begin
         run_q  <= '0;
      end else if (tick_i) begin
         run_q  <= run_nxt;
         last_q <= sample_i;
         if (accept) held_q <= sample_i;
      end
   end

   assign held_o = held_q;

   // R1: the stored level moves only on a sampling instant or a clear
   a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clear_i) && !$past(tick_i)) |-> $stable(held_q));

   // R8: disabling resets the stored level to the invert setting
   a_r8_clear_level: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (held_q == $past(clear_val_i)) && (run_q == '0));

   // R9: a differing sample restarts the run at one
   a_r9_mismatch_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !clear_i && !restart_i && run_q != '0 && sample_i != last_q)
      |=> run_q == RUN_ONE);
endmodule

// File: rtl/cmp_out_filter.sv
module cmp_out_filter
   import cof_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 3,
   parameter int PER_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             inv_i,
   input  logic             ext_sample_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [PER_W-1:0] period_i,
   input  logic             cmp_raw_i,
   input  logic             strobe_i,
   output logic             filt_o,
   output logic             unfilt_o
);
   localparam int CFG_W = 1 + CNT_W + PER_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cmp_out_filter: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("cmp_out_filter: CNT_W out of range");
   end
   if (PER_W < 1) begin : g_bad_per
      $error("cmp_out_filter: PER_W must be positive");
   end

   tick_src_e        src;
   logic             raw_s;
   logic             tick;
   logic             held;
   logic             restart;
   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;

   assign src     = tick_src_e'(ext_sample_i);
   assign cfg_now = {ext_sample_i, cnt_i, period_i};
   assign restart = (cfg_now != cfg_q) || !en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_now;
   end

   cof_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_raw_i),
      .q_o   (raw_s)
   );

   assign unfilt_o = en_i ? (raw_s ^ inv_i) : inv_i;

   cof_tick_gen #(.PER_W(PER_W)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src),
      .period_i  (period_i),
      .strobe_i  (strobe_i),
      .restart_i (restart),
      .tick_o    (tick)
   );

   cof_agree #(.CNT_W(CNT_W)) u_agree (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (!en_i),
      .clear_val_i (inv_i),
      .restart_i   (restart),
      .tick_i      (tick),
      .sample_i    (unfilt_o),
      .need_i      (cnt_i),
      .held_o      (held)
   );

   always_comb begin
      if (!en_i)
         filt_o = inv_i;
      else if (cnt_i == '0)
         filt_o = (src == TICK_STROBE) ? 1'b0 : unfilt_o;
      else if ((src == TICK_PERIOD) && (period_i == '0))
         filt_o = unfilt_o;
      else
         filt_o = held;
   end

   // R10: a settings change leaves the stored level untouched
   a_r10_hold_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && cfg_now != cfg_q) |=> $stable(held));
endmodule

// File: tb/cmp_out_filter_bench.sv
module cmp_out_filter_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       en_i, inv_i, ext_sample_i, cmp_raw_i, strobe_i;
   logic [2:0] cnt_i;
   logic [7:0] period_i;
   logic       filt_o, unfilt_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmp_out_filter u_cmp_out_filter (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en_i),
      .inv_i        (inv_i),
      .ext_sample_i (ext_sample_i),
      .cnt_i        (cnt_i),
      .period_i     (period_i),
      .cmp_raw_i    (cmp_raw_i),
      .strobe_i     (strobe_i),
      .filt_o       (filt_o),
      .unfilt_o     (unfilt_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cfg(input bit ext, input int cnt, input int per);
      @(negedge clk);
      ext_sample_i = ext;
      cnt_i        = 3'(cnt);
      period_i     = 8'(per);
   endtask

   task automatic pulse();
      @(negedge clk); strobe_i = 1'b1;
      @(negedge clk); strobe_i = 1'b0;
      @(negedge clk);
   endtask

   // drive raw at a negedge, count edges until filt_o equals lvl
   task automatic measure(input bit lvl, output int edges);
      @(negedge clk);
      cmp_raw_i = lvl;
      edges = 0;
      while (filt_o != lvl && edges < 2000) begin
         @(negedge clk);
         edges++;
      end
   endtask

   initial begin
      int lat;
      bit seen;
      rst_n = 1'b0; en_i = 1'b0; inv_i = 1'b0; ext_sample_i = 1'b0;
      cnt_i = '0; period_i = '0; cmp_raw_i = 1'b0; strobe_i = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      // R11 reset state
      chk(filt_o == 1'b0, "R11 filt after reset", filt_o, 0);
      chk(unfilt_o == 1'b0, "R11 unfilt after reset", unfilt_o, 0);

      // R1 / R2: exact latency with a period of one
      en_i = 1'b1;
      for (int n = 1; n <= 7; n++) begin
         set_cfg(1'b0, n, 1);
         cmp_raw_i = 1'b0;
         wait_n(20);
         chk(filt_o == 1'b0, (n == 1) ? "R2 settled low" : "R1 settled low", filt_o, 0);
         measure(1'b1, lat);
         chk(lat == n + 2, (n == 1) ? "R2 rise latency" : "R1 rise latency", lat, n + 2);
         wait_n(5);
         measure(1'b0, lat);
         chk(lat == n + 2, (n == 1) ? "R2 fall latency" : "R1 fall latency", lat, n + 2);
      end

      // R5: latency window for longer periods
      for (int p = 2; p <= 4; p++) begin
         for (int n = 1; n <= 3; n++) begin
            set_cfg(1'b0, n, p);
            cmp_raw_i = 1'b0;
            wait_n(30);
            measure(1'b1, lat);
            chk(lat >= 3 + (n - 1) * p && lat <= 2 + n * p, "R5 period window", lat, 2 + n * p);
         end
      end

      // R5: period zero bypasses the filter
      set_cfg(1'b0, 3, 0);
      cmp_raw_i = 1'b1;
      wait_n(2);
      chk(filt_o == 1'b1, "R5 period zero follows", filt_o, 1);
      cmp_raw_i = 1'b0;
      wait_n(2);
      chk(filt_o == 1'b0, "R5 period zero follows low", filt_o, 0);

      // R3: count zero in counter mode follows unfiltered
      set_cfg(1'b0, 0, 5);
      cmp_raw_i = 1'b1;
      wait_n(2);
      chk(filt_o == 1'b1, "R3 count zero follows", filt_o, 1);

      // R4: count zero in strobe mode forces low
      set_cfg(1'b1, 0, 5);
      wait_n(4);
      chk(filt_o == 1'b0, "R4 forced low", filt_o, 0);
      chk(unfilt_o == 1'b1, "R4 unfilt still high", unfilt_o, 1);

      // R7: invert and synchronizer latency
      set_cfg(1'b0, 0, 1);
      cmp_raw_i = 1'b0;
      inv_i = 1'b1;
      wait_n(4);
      chk(unfilt_o == 1'b1, "R7 inverted low input", unfilt_o, 1);
      chk(filt_o == 1'b1, "R7 filt inverted", filt_o, 1);
      cmp_raw_i = 1'b1;
      wait_n(1);
      chk(unfilt_o == 1'b1, "R7 one edge not yet", unfilt_o, 1);
      wait_n(1);
      chk(unfilt_o == 1'b0, "R7 two edge arrival", unfilt_o, 0);
      inv_i = 1'b0;

      // R6: strobe sampling, exact pulse counts, period ignored
      for (int n = 1; n <= 7; n++) begin
         set_cfg(1'b1, n, 0);
         cmp_raw_i = 1'b0;
         wait_n(3);
         repeat (8) pulse();
         chk(filt_o == 1'b0, "R6 strobe settled low", filt_o, 0);
         cmp_raw_i = 1'b1;
         wait_n(3);
         repeat (n - 1) pulse();
         chk(filt_o == 1'b0, "R6 one pulse short", filt_o, 0);
         pulse();
         chk(filt_o == 1'b1, "R6 accepted on last pulse", filt_o, 1);
      end
      // R6: held strobe counts once
      set_cfg(1'b1, 2, 0);
      cmp_raw_i = 1'b0;
      wait_n(3);
      strobe_i = 1'b1;
      wait_n(6);
      strobe_i = 1'b0;
      wait_n(2);
      chk(filt_o == 1'b1, "R6 long strobe single sample", filt_o, 1);
      pulse();
      chk(filt_o == 1'b0, "R6 second edge accepts", filt_o, 0);

      // R9: short pulses rejected, long one passes
      set_cfg(1'b0, 4, 1);
      cmp_raw_i = 1'b0;
      wait_n(20);
      for (int w = 2; w <= 4; w++) begin
         seen = 1'b0;
         @(negedge clk); cmp_raw_i = 1'b1;
         wait_n(w);
         cmp_raw_i = 1'b0;
         for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            if (filt_o) seen = 1'b1;
         end
         chk(seen == (w == 4), "R9 pulse width filter", seen, (w == 4));
      end

      // R10: settings change restarts run, keeps level
      set_cfg(1'b1, 3, 0);
      cmp_raw_i = 1'b0;
      wait_n(3);
      repeat (8) pulse();
      cmp_raw_i = 1'b1;
      wait_n(3);
      repeat (2) pulse();
      set_cfg(1'b1, 4, 0);
      wait_n(2);
      chk(filt_o == 1'b0, "R10 level kept after change", filt_o, 0);
      repeat (2) pulse();
      chk(filt_o == 1'b0, "R10 run restarted", filt_o, 0);
      repeat (2) pulse();
      chk(filt_o == 1'b1, "R10 accepted after full run", filt_o, 1);

      // R8: disable reads invert setting, clears stored level
      set_cfg(1'b0, 2, 1);
      wait_n(10);
      chk(filt_o == 1'b1, "R8 stored high before disable", filt_o, 1);
      en_i = 1'b0; inv_i = 1'b1;
      wait_n(1);
      chk(filt_o == 1'b1 && unfilt_o == 1'b1, "R8 disabled reads inv=1", filt_o, 1);
      inv_i = 1'b0;
      wait_n(1);
      chk(filt_o == 1'b0 && unfilt_o == 1'b0, "R8 disabled reads inv=0", filt_o, 0);
      en_i = 1'b1;
      wait_n(1);
      chk(filt_o == 1'b0, "R8 stored level was cleared", filt_o, 0);
      wait_n(10);
      chk(filt_o == 1'b1, "R8 filter resumes", filt_o, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule